// File: doc/BRIEF.md
# Power-of-Two Period Watchdog Timer

This block is a watchdog peripheral with a single-cycle register port. Software picks a timeout of 1, 2, 4 and so on up to 128 seconds by writing a small encoded period code. It starts the timer by writing enable and clear together to the control register. It keeps the timer from expiring by writing clear again (a "kick") before the period runs out. A status bit tells software that the counter has been reloaded after a clear, and that bit reads low whenever the timer is off.

The seconds time base comes from an internal prescaler that divides the input clock by a parameter. When the count runs out, the block raises a level interrupt. Depending on a select register, it can also raise a reset request pulse of fixed length. Turning the enable off freezes the timer and withdraws the interrupt. While the timer is off, no expiry can happen.

Top module: `pow2_watchdog`

## Requirements
- R1: After a synchronous reset, the block is disabled with period code 3 and select 0. Both irq_o and rst_req_o are low, and a read of the control register returns 0.
- R2: The period code is held in bits [3:0] at offset 0x3004. A written value below 3 is stored as 3 and a value above 10 is stored as 10, and reads return the stored code.
- R3: The timeout is 2^(code-3) seconds, and one second is TICKS_PER_SEC clock cycles. irq_o rises at the clock edge that is exactly 2^(code-3)*TICKS_PER_SEC edges after the edge that accepted the start write.
- R4: At offset 0x300C, bit 0 is enable and bit 1 is clear. A clear reloads the counter only when it is written with bit 0 set; a clear written with bit 0 low has no effect. Bit 1 always reads back as 0.
- R5: Control bit 8 is a read-only status bit. It is 1 from the edge after a reload until the timer is disabled, and it is 0 whenever enable is 0.
- R6: A clear written while the timer runs restarts the full period from the edge that accepted it.
- R7: Writing enable as 0 stops the countdown and drops irq_o. No interrupt or reset request is produced while the timer is disabled.
- R8: The select register holds bits [1:0] at offset 0x3008. When bit 1 is 0, expiry drives both irq_o and rst_req_o. When bit 1 is 1, expiry drives irq_o only.
- R9: rst_req_o is high for exactly RST_PULSE_LEN cycles, starting at the expiry edge. irq_o stays high until the next clear or disable.
- R10: Each reload gives at most one expiry. After expiry the timer stays idle, with no further reset pulse, until it is cleared again.
- R11: A read of any address other than the three registers returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; bus_rdata updates at the same edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Expiry interrupt level |
| rst_req_o | output | 1 | Expiry reset request pulse |

## Verification
The hardest states to reach are the ones that depend on the exact edge on which the count runs out. These are the expiry itself, a kick that lands just before it, and a disable partway through the count. The bench shortens the second to four clocks through the parameter. It issues every access from a task that starts at a falling edge, so the accepting rising edge is known. It then counts edges from that point to sample irq_o and rst_req_o one edge before and at the predicted expiry. The longest period (code 10) is run in full to confirm the upper clamp and the full counter width.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int unsigned CODE_MIN = 3;
  localparam int unsigned CODE_MAX = 10;
  localparam logic [15:0] OFS_PERIOD = 16'h3004;
  localparam logic [15:0] OFS_SELECT = 16'h3008;
  localparam logic [15:0] OFS_CTRL   = 16'h300C;
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_CLR    = 1;
  localparam int unsigned BIT_STAT   = 8;
  localparam int unsigned BIT_IRQONLY = 1;
  typedef logic [3:0] period_code_t;
endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              status,
  output logic [DATA_W-1:0] rdata,
  output period_code_t      code,
  output logic              irq_only,
  output logic              en,
  output logic              load,
  output logic              halt
);
  logic hit_per, hit_sel, hit_ctl, wr_ctl;
  period_code_t code_in;

  assign hit_per = (addr == ADDR_W'(OFS_PERIOD));
  assign hit_sel = (addr == ADDR_W'(OFS_SELECT));
  assign hit_ctl = (addr == ADDR_W'(OFS_CTRL));
  assign wr_ctl  = wr && hit_ctl;
  assign load    = wr_ctl && wdata[BIT_EN] && wdata[BIT_CLR];
  assign halt    = wr_ctl && !wdata[BIT_EN];

  always_comb begin
    code_in = wdata[3:0];
    if (code_in < period_code_t'(CODE_MIN))      code_in = period_code_t'(CODE_MIN);
    else if (code_in > period_code_t'(CODE_MAX)) code_in = period_code_t'(CODE_MAX);
  end

  logic [1:0] sel_q;
  assign irq_only = sel_q[BIT_IRQONLY];

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= period_code_t'(CODE_MIN);
      sel_q <= 2'b00;
      en    <= 1'b0;
    end else if (wr) begin
      if (hit_per) code  <= code_in;
      if (hit_sel) sel_q <= wdata[1:0];
      if (hit_ctl) en    <= wdata[BIT_EN];
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_per) rd_mux[3:0] = code;
    if (hit_sel) rd_mux[1:0] = sel_q;
    if (hit_ctl) begin
      rd_mux[BIT_EN]   = en;
      rd_mux[BIT_STAT] = status;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
  parameter int TICKS_PER_SEC = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (TICKS_PER_SEC <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      localparam int PW = $clog2(TICKS_PER_SEC);
      localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);
      logic [PW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || restart)  cnt <= '0;
        else if (run)        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
      assign tick = run && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int RST_PULSE_LEN = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         load,
  input  logic         halt,
  input  logic         tick,
  input  period_code_t code,
  input  logic         irq_only,
  output logic         status,
  output logic         irq,
  output logic         rst_req
);
  localparam int PCW = $clog2(RST_PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;
  logic             fire;
  logic [PCW-1:0]   pcnt;

  assign reload = CNT_W'(1) << (code - period_code_t'(CODE_MIN));
  assign fire   = run && tick && (cnt == CNT_W'(1)) && !load && !halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      status <= 1'b0;
      irq    <= 1'b0;
    end else if (load) begin
      cnt    <= reload;
      status <= 1'b1;
      irq    <= 1'b0;
    end else if (halt) begin
      cnt    <= '0;
      status <= 1'b0;
      irq    <= 1'b0;
    end else if (fire) begin
      cnt    <= '0;
      irq    <= 1'b1;
    end else if (run && tick && cnt != '0) begin
      cnt    <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
      pcnt    <= '0;
    end else if (fire && !irq_only) begin
      rst_req <= 1'b1;
      pcnt    <= PCW'(RST_PULSE_LEN - 1);
    end else if (pcnt != '0) begin
      pcnt    <= pcnt - 1'b1;
    end else begin
      rst_req <= 1'b0;
    end
  end
endmodule

// File: rtl/pow2_watchdog.sv
`timescale 1ns/1ps
module pow2_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 32,
  parameter int TICKS_PER_SEC = 50_000_000,
  parameter int RST_PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int CNT_W = CODE_MAX - CODE_MIN + 1;

  period_code_t period_code;
  logic irq_only, en_q, load, halt, status, tick;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .status(status), .rdata(bus_rdata),
    .code(period_code), .irq_only(irq_only), .en(en_q),
    .load(load), .halt(halt)
  );

  wdt_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst(rst), .run(en_q), .restart(load), .tick(tick)
  );

  wdt_countdown #(.CNT_W(CNT_W), .RST_PULSE_LEN(RST_PULSE_LEN)) u_cnt (
    .clk(clk), .rst(rst), .run(en_q), .load(load), .halt(halt),
    .tick(tick), .code(period_code), .irq_only(irq_only),
    .status(status), .irq(irq_o), .rst_req(rst_req_o)
  );
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic              en,
  input logic              status,
  input logic              load,
  input logic [3:0]        code
);
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (code >= 4'(CODE_MIN)) && (code <= 4'(CODE_MAX))); // R2
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_CTRL)) |=> !bus_rdata[BIT_CLR]); // R4
  AST_STATUS_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> status); // R5
  AST_STATUS_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |-> !status); // R5
  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |-> !irq_o); // R7
  AST_RST_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> irq_o); // R8
endmodule

bind pow2_watchdog wdt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o),
  .en(en_q), .status(status), .load(load), .code(period_code)
);

// File: tb/pow2_watchdog_test.sv
`timescale 1ns/1ps
module pow2_watchdog_test;
  localparam int T   = 4;
  localparam int LEN = 3;
  localparam logic [15:0] A_PER = 16'h3004, A_SEL = 16'h3008, A_CTL = 16'h300C;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, rst_req_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pow2_watchdog #(.ADDR_W(16), .DATA_W(32), .TICKS_PER_SEC(T), .RST_PULSE_LEN(LEN)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq", irq_o, 0);
    check("R1 rst_req", rst_req_o, 0);
    rd(A_PER, v); check("R1 period", v, 3);
    rd(A_SEL, v); check("R1 select", v, 0);
    rd(A_CTL, v); check("R1 ctrl", v, 0);
    rd(16'h3000, v); check("R11 unmapped", v, 0);
  endtask

  task automatic t_clamp;
    logic [31:0] v;
    wr(A_PER, 0);  rd(A_PER, v); check("R2 low clamp", v, 3);
    wr(A_PER, 15); rd(A_PER, v); check("R2 high clamp", v, 10);
    wr(A_PER, 6);  rd(A_PER, v); check("R2 legal code", v, 6);
  endtask

  task automatic t_timeout(input int code);
    logic [31:0] v;
    int n;
    n = (1 << (code - 3)) * T;
    wr(A_SEL, 0);
    wr(A_PER, code);
    wr(A_CTL, 3);
    edges(n - 1);
    check("R3 before expiry", irq_o, 0);
    edges(1);
    check("R3 at expiry", irq_o, 1);
    check("R9 rst pulse start", rst_req_o, 1);
    edges(LEN - 1);
    check("R9 rst pulse last", rst_req_o, 1);
    edges(1);
    check("R9 rst pulse end", rst_req_o, 0);
    check("R9 irq level holds", irq_o, 1);
    edges(3 * n);
    check("R10 no second pulse", rst_req_o, 0);
    rd(A_CTL, v); check("R4 clear reads 0", v[1], 0);
    wr(A_CTL, 0);
    check("R7 disable drops irq", irq_o, 0);
    rd(A_CTL, v); check("R5 status low off", v[8], 0);
  endtask

  task automatic t_status;
    logic [31:0] v;
    wr(A_PER, 3);
    rd(A_CTL, v); check("R5 status before start", v[8], 0);
    wr(A_CTL, 3);
    rd(A_CTL, v); check("R5 status after load", v, 32'h101);
    wr(A_CTL, 0);
  endtask

  task automatic t_kick;
    wr(A_PER, 4);
    wr(A_CTL, 3);
    edges(5);
    wr(A_CTL, 3);
    edges(7);
    check("R6 kick delays expiry", irq_o, 0);
    edges(1);
    check("R6 expiry after kick", irq_o, 1);
    wr(A_CTL, 0);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    wr(A_PER, 3);
    wr(A_CTL, 3);
    edges(2);
    wr(A_CTL, 0);
    edges(20);
    check("R7 no irq while off", irq_o, 0);
    check("R7 no rst while off", rst_req_o, 0);
    wr(A_CTL, 2);
    edges(20);
    check("R4 clear without enable ignored irq", irq_o, 0);
    rd(A_CTL, v); check("R4 clear without enable ctrl", v, 0);
  endtask

  task automatic t_irq_only;
    wr(A_SEL, 2);
    wr(A_PER, 3);
    wr(A_CTL, 3);
    edges(T);
    check("R8 irq only irq", irq_o, 1);
    check("R8 irq only no rst", rst_req_o, 0);
    edges(LEN + 2);
    check("R8 irq only no rst later", rst_req_o, 0);
    wr(A_CTL, 0);
    wr(A_SEL, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_clamp;
    t_status;
    t_timeout(3);
    t_timeout(5);
    t_timeout(10);
    t_kick;
    t_disable;
    t_irq_only;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule